// File: doc/BRIEF.md
# Transparent serial channel synchronizer

This block sits at the bit-serial front end of a transparent (flagless) receive/transmit channel. It decides when received bits start to be delivered and when the transmitter may stop sending idle ones and start sending real data. The start of data is chosen by one of three start modes.

- **Word mode** hunts for a programmable 16-bit sync word in the incoming stream.
- **Open mode** treats the channel as aligned from the moment it is enabled.
- **Strobe mode** waits for a falling edge on a shared, asynchronous, active-low carrier/clear line.

Delivered bits are packed MSB-first into bytes on a valid/ready output. The stream carries no closing flag, so the end of a frame is taken from the deassertion of the same carrier line. That event flushes any partial byte together with a count of its valid bits.

One cycle of `clk` is a bit time whenever `bit_en` is high. The transmit side drives ones until it is released. Release happens either at enable, or a fixed number of bit times after the receiver aligns. A loopback receiver therefore sees all-ones bytes before the payload.

Top module: `tsc_sync_top`

## Requirements
- R1: After reset, `byte_valid` and `rx_synced` are 0, `tx_line` is 1 and `tx_take` is 0.
- R2: With `start_mode` = 2'b00 (word mode; 2'b11 behaves the same), no byte is produced until the last 16 bits taken with `bit_en` equal `sync_word`, compared MSB first. `rx_synced` is high from the clock after the matching bit. The first delivered bit is the next one taken with `bit_en`.
- R3: In word mode a match counts only after at least 16 bits have been taken since enable or since the last re-hunt. A shorter history never matches, whatever `sync_word` holds.
- R4: With `start_mode` = 2'b01 (open mode), every bit taken with `bit_en` while `chan_en` is high is delivered, starting with the first such clock. No leading bit is lost.
- R5: With `start_mode` = 2'b10 (strobe mode), let edge k be the clock that first samples `link_n` low after it was high. `rx_synced` rises after edge k+2, and bits taken from edge k+3 onward are delivered.
- R6: Bytes are packed MSB first: the earliest delivered bit lands in `byte_data[7]`. A byte completed by its eighth bit has `byte_nbits` = 8 and `byte_last` = 0.
- R7: Let edge k be the clock that first samples `link_n` high after it was low, while aligned (or in open mode). At edge k+2, the pending bits, including any bit taken at that edge, are emitted with `byte_last` = 1. They sit MSB-aligned, `byte_nbits` holds their count (0 to 8) and the unused low bits are 0. Word and strobe modes then drop `rx_synced` and hunt again.
- R8: With `tx_follow` = 1, `tx_line` stays 1 and `tx_take` stays 0 during the first 8 `bit_en` clocks seen with `rx_synced` high. From the ninth such clock, `tx_take` = `bit_en` and `tx_line` = `tx_src_bit`. With `tx_follow` = 0, release occurs on the clock after `chan_en` is first seen high.
- R9: Clearing `chan_en` clears alignment, pending bits and the transmit release. On re-enable, word mode needs a fresh 16-bit match.
- R10: While `byte_valid` is high and `byte_ready` is low, the byte and its flags hold still. A byte completed while the output holds an unaccepted byte is dropped.
- R11: In word and open modes, a falling edge on `link_n` neither aligns the receiver nor produces output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; a bit time when `bit_en` is high |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_en | input | 1 | Channel enable; low clears alignment |
| start_mode | input | 2 | 00 word, 01 open, 10 strobe, 11 as word |
| sync_word | input | 16 | Word searched for in word mode |
| tx_follow | input | 1 | Hold transmit until 8 bit times after receive alignment |
| link_n | input | 1 | Asynchronous active-low carrier/clear line |
| bit_en | input | 1 | Bit-time enable for receive and transmit |
| rx_bit | input | 1 | Received serial bit |
| byte_data | output | 8 | Packed byte, MSB first |
| byte_valid | output | 1 | Byte available |
| byte_ready | input | 1 | Consumer accepts the byte |
| byte_last | output | 1 | Byte ends a frame |
| byte_nbits | output | 4 | Count of valid bits in the byte (0 to 8) |
| rx_synced | output | 1 | Receiver aligned |
| tx_src_bit | input | 1 | Next bit to transmit once released |
| tx_take | output | 1 | `tx_src_bit` is consumed this bit time |
| tx_line | output | 1 | Serial transmit line; 1 while idle |

## Verification
A wrong alignment flag shows up in two ways. It shifts or drops the first delivered byte. In follow mode it also moves the transmit release by whole bit times, so `byte_data`, `rx_synced` and `tx_line` disagree with the bench model within eight to sixteen bit times of the fault. A corrupted fill or pattern history gives an early or late `rx_synced` on the very clock after the offending bit. A bad packing count shows at the next completed or flushed byte as a wrong `byte_nbits` or shifted data. Because the reference model is compared on every clock, each of these faults is reported in the cycle it first reaches a port.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic [1:0] {
    MODE_WORD   = 2'b00,
    MODE_OPEN   = 2'b01,
    MODE_STROBE = 2'b10,
    MODE_SPARE  = 2'b11
  } start_mode_e;

endpackage

// File: rtl/tsc_cdc.sv
module tsc_cdc #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_n,
  output logic fall_seen,
  output logic rise_seen
);

  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d[0] = link_n;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_comb begin
      pipe_d[g] = pipe_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign fall_seen = pipe_q[STAGES] & ~pipe_q[STAGES-1];
  assign rise_seen = ~pipe_q[STAGES] & pipe_q[STAGES-1];

endmodule

// File: rtl/tsc_align.sv
module tsc_align
  import tsc_pkg::*;
#(
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  start_mode_e      mode,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic [PAT_W-1:0] sync_word,
  input  logic             fall_seen,
  input  logic             rise_seen,
  output logic             synced,
  output logic             accept,
  output logic             eof
);

  localparam int FW = $clog2(PAT_W + 1);
  localparam logic [FW-1:0] FILL_MAX  = FW'(PAT_W);
  localparam logic [FW-1:0] FILL_LAST = FW'(PAT_W - 1);

  logic             synced_q, synced_d;
  logic [FW-1:0]    fill_q, fill_d;
  logic [PAT_W-1:0] hist_q, hist_d;
  logic [PAT_W-1:0] cand;
  logic             open_mode;

  assign open_mode = (mode == MODE_OPEN);
  assign cand      = {hist_q[PAT_W-2:0], rx_bit};
  assign accept    = chan_en & bit_en & (synced_q | open_mode);
  assign eof       = chan_en & rise_seen & (synced_q | open_mode);
  assign synced    = synced_q;

  always_comb begin
    synced_d = synced_q;
    fill_d   = fill_q;
    hist_d   = hist_q;
    if (!chan_en) begin
      synced_d = 1'b0;
      fill_d   = '0;
      hist_d   = '0;
    end else if (open_mode) begin
      synced_d = 1'b1;
    end else if (eof) begin
      synced_d = 1'b0;
      fill_d   = '0;
    end else if (!synced_q) begin
      if (mode == MODE_STROBE) begin
        if (fall_seen) begin
          synced_d = 1'b1;
        end
      end else if (bit_en) begin
        hist_d = cand;
        if (fill_q != FILL_MAX) begin
          fill_d = fill_q + 1'b1;
        end
        if ((fill_q >= FILL_LAST) && (cand == sync_word)) begin
          synced_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced_q <= 1'b0;
      fill_q   <= '0;
      hist_q   <= '0;
    end else begin
      synced_q <= synced_d;
      fill_q   <= fill_d;
      hist_q   <= hist_d;
    end
  end

endmodule

// File: rtl/tsc_pack.sv
module tsc_pack #(
  parameter int DATA_W = 8,
  localparam int NBW = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              accept,
  input  logic              rx_bit,
  input  logic              eof,
  input  logic              byte_ready,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_valid,
  output logic              byte_last,
  output logic [NBW-1:0]    byte_nbits
);

  localparam logic [NBW-1:0] FULL = NBW'(DATA_W);

  logic [DATA_W-2:0] sr_q, sr_d;
  logic [NBW-1:0]    cnt_q, cnt_d;
  logic [DATA_W-1:0] val;
  logic [NBW-1:0]    nb;
  logic              emit;
  logic [DATA_W-1:0] e_data;
  logic              e_last;

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              lst_q, lst_d;
  logic [NBW-1:0]    nbt_q, nbt_d;

  assign val = accept ? {sr_q, rx_bit} : {1'b0, sr_q};
  assign nb  = cnt_q + {{(NBW-1){1'b0}}, accept};

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    emit   = 1'b0;
    e_data = val;
    e_last = 1'b0;
    if (!chan_en) begin
      cnt_d = '0;
    end else if (eof) begin
      emit   = 1'b1;
      e_data = val << (FULL - nb);
      e_last = 1'b1;
      cnt_d  = '0;
    end else if (nb == FULL) begin
      emit  = 1'b1;
      cnt_d = '0;
    end else if (accept) begin
      sr_d  = val[DATA_W-2:0];
      cnt_d = nb;
    end
  end

  always_comb begin
    vld_d = vld_q;
    dat_d = dat_q;
    lst_d = lst_q;
    nbt_d = nbt_q;
    if (emit && (!vld_q || byte_ready)) begin
      vld_d = 1'b1;
      dat_d = e_data;
      lst_d = e_last;
      nbt_d = nb;
    end else if (byte_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
      dat_q <= '0;
      lst_q <= 1'b0;
      nbt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      vld_q <= vld_d;
      dat_q <= dat_d;
      lst_q <= lst_d;
      nbt_q <= nbt_d;
    end
  end

  assign byte_valid = vld_q;
  assign byte_data  = dat_q;
  assign byte_last  = lst_q;
  assign byte_nbits = nbt_q;

endmodule

// File: rtl/tsc_txgate.sv
module tsc_txgate #(
  parameter int TX_GAP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic tx_follow,
  input  logic synced,
  input  logic bit_en,
  input  logic tx_src_bit,
  output logic tx_take,
  output logic tx_line
);

  localparam int GW = $clog2(TX_GAP + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(TX_GAP - 1);

  logic          rel_q, rel_d;
  logic [GW-1:0] tcnt_q, tcnt_d;
  logic          live;

  always_comb begin
    rel_d  = rel_q;
    tcnt_d = tcnt_q;
    if (!chan_en) begin
      rel_d  = 1'b0;
      tcnt_d = '0;
    end else if (!tx_follow) begin
      rel_d = 1'b1;
    end else if (!rel_q && synced && bit_en) begin
      if (tcnt_q == GAP_LAST) begin
        rel_d = 1'b1;
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q  <= 1'b0;
      tcnt_q <= '0;
    end else begin
      rel_q  <= rel_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign live    = chan_en & rel_q;
  assign tx_take = live & bit_en;
  assign tx_line = live ? tx_src_bit : 1'b1;

endmodule

// File: rtl/tsc_sync_top.sv
module tsc_sync_top
  import tsc_pkg::*;
#(
  parameter int PAT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int TX_GAP      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NBW = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic [1:0]        start_mode,
  input  logic [PAT_W-1:0]  sync_word,
  input  logic              tx_follow,
  input  logic              link_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic              byte_last,
  output logic [NBW-1:0]    byte_nbits,
  output logic              rx_synced,
  input  logic              tx_src_bit,
  output logic              tx_take,
  output logic              tx_line
);

  logic [1:0]  rst_pipe;
  logic        rst_int_n;
  logic        fall_seen, rise_seen;
  logic        accept, eof;
  start_mode_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe[1];
  assign mode      = start_mode_e'(start_mode);

  tsc_cdc #(.STAGES(SYNC_STAGES)) cdc_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .link_n    (link_n),
    .fall_seen (fall_seen),
    .rise_seen (rise_seen)
  );

  tsc_align #(.PAT_W(PAT_W)) align_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .chan_en   (chan_en),
    .mode      (mode),
    .bit_en    (bit_en),
    .rx_bit    (rx_bit),
    .sync_word (sync_word),
    .fall_seen (fall_seen),
    .rise_seen (rise_seen),
    .synced    (rx_synced),
    .accept    (accept),
    .eof       (eof)
  );

  tsc_pack #(.DATA_W(DATA_W)) pack_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .chan_en    (chan_en),
    .accept     (accept),
    .rx_bit     (rx_bit),
    .eof        (eof),
    .byte_ready (byte_ready),
    .byte_data  (byte_data),
    .byte_valid (byte_valid),
    .byte_last  (byte_last),
    .byte_nbits (byte_nbits)
  );

  tsc_txgate #(.TX_GAP(TX_GAP)) tx_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .chan_en    (chan_en),
    .tx_follow  (tx_follow),
    .synced     (rx_synced),
    .bit_en     (bit_en),
    .tx_src_bit (tx_src_bit),
    .tx_take    (tx_take),
    .tx_line    (tx_line)
  );

endmodule

// File: rtl/tsc_sync_chk.sv
module tsc_sync_chk #(
  parameter int DATA_W = 8,
  parameter int NBW    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chan_en,
  input logic [1:0]        start_mode,
  input logic              bit_en,
  input logic [DATA_W-1:0] byte_data,
  input logic              byte_valid,
  input logic              byte_ready,
  input logic              byte_last,
  input logic [NBW-1:0]    byte_nbits,
  input logic              rx_synced,
  input logic              tx_take,
  input logic              tx_line
);

  logic [DATA_W-1:0] spill;
  assign spill = byte_data << byte_nbits;

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data) &&
                                     $stable(byte_last) && $stable(byte_nbits)));

  assert_disable_drops_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !rx_synced);

  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> (tx_line && !tx_take));

  assert_take_on_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> bit_en);

  assert_full_byte_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_last) |-> (byte_nbits == NBW'(DATA_W)));

  assert_flush_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (spill == '0));

  assert_word_sync_on_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_synced) && ($past(start_mode) == 2'b00)) |-> $past(bit_en));

endmodule

bind tsc_sync_top tsc_sync_chk #(.DATA_W(DATA_W), .NBW(NBW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_en    (chan_en),
  .start_mode (start_mode),
  .bit_en     (bit_en),
  .byte_data  (byte_data),
  .byte_valid (byte_valid),
  .byte_ready (byte_ready),
  .byte_last  (byte_last),
  .byte_nbits (byte_nbits),
  .rx_synced  (rx_synced),
  .tx_take    (tx_take),
  .tx_line    (tx_line)
);

// File: tb/tsc_sync_top_tb_top.sv
module tsc_sync_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0;
  logic [1:0]  start_mode = 2'b00;
  logic [15:0] sync_word = 16'h0000;
  logic        tx_follow = 1'b0;
  logic        link_n = 1'b1;
  logic        bit_en = 1'b0;
  logic        rx_bit = 1'b0;
  logic        byte_ready = 1'b1;
  logic        tx_src_bit = 1'b0;
  logic [7:0]  byte_data;
  logic        byte_valid, byte_last, rx_synced, tx_take, tx_line;
  logic [3:0]  byte_nbits;

  int  checks = 0;
  int  fails = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  tsc_sync_top dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .start_mode(start_mode),
    .sync_word(sync_word), .tx_follow(tx_follow), .link_n(link_n),
    .bit_en(bit_en), .rx_bit(rx_bit), .byte_data(byte_data),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_last(byte_last),
    .byte_nbits(byte_nbits), .rx_synced(rx_synced), .tx_src_bit(tx_src_bit),
    .tx_take(tx_take), .tx_line(tx_line)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       l1 = 1, l2 = 1, l3 = 1;
  bit       m_sync = 0, m_vld = 0, m_last = 0, m_rel = 0;
  logic [7:0] m_data = 0;
  int       m_nb = 0, m_tcnt = 0;
  bit       pq[$];
  bit       hq[$];

  always @(posedge clk) begin : model
    bit fall_e, rise_e, inh, strb, acc, eof, nsync, emit, el;
    logic [7:0] ed;
    logic [15:0] win;
    int en;
    if (!rst_n) begin
      l1 = 1; l2 = 1; l3 = 1;
      m_sync = 0; m_vld = 0; m_last = 0; m_rel = 0; m_data = 0;
      m_nb = 0; m_tcnt = 0; pq.delete(); hq.delete();
    end else begin
      fall_e = l3 && !l2;
      rise_e = !l3 && l2;
      l3 = l2; l2 = l1; l1 = link_n;
      inh  = (start_mode == 2'b01);
      strb = (start_mode == 2'b10);
      acc  = chan_en && bit_en && (m_sync || inh);
      eof  = chan_en && rise_e && (m_sync || inh);
      nsync = m_sync;
      if (!chan_en) begin
        nsync = 0; hq.delete();
      end else if (inh) begin
        nsync = 1;
      end else if (eof) begin
        nsync = 0; hq.delete();
      end else if (!m_sync) begin
        if (strb) begin
          if (fall_e) nsync = 1;
        end else if (bit_en) begin
          hq.push_back(rx_bit);
          if (hq.size() > 16) void'(hq.pop_front());
          if (hq.size() == 16) begin
            win = 0;
            foreach (hq[i]) win = {win[14:0], hq[i]};
            if (win == sync_word) nsync = 1;
          end
        end
      end
      emit = 0; ed = 0; en = 0; el = 0;
      if (!chan_en) pq.delete();
      else begin
        if (acc) pq.push_back(rx_bit);
        if (eof || pq.size() == 8) begin
          emit = 1;
          foreach (pq[i]) ed[7-i] = pq[i];
          en = pq.size();
          el = eof;
          pq.delete();
        end
      end
      if (emit && (!m_vld || byte_ready)) begin
        m_vld = 1; m_data = ed; m_nb = en; m_last = el;
      end else if (byte_ready) m_vld = 0;
      if (!chan_en) begin
        m_rel = 0; m_tcnt = 0;
      end else if (!tx_follow) m_rel = 1;
      else if (!m_rel && m_sync && bit_en) begin
        m_tcnt++;
        if (m_tcnt == 8) m_rel = 1;
      end
      m_sync = nsync;
    end
  end

  // ---------------- per-clock comparison and capture ----------------
  logic [7:0] gd[$];
  int         gn[$];
  bit         gl[$];

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      string stag;
      bit exp_line;
      stag = (start_mode == 2'b01) ? "R4" : (start_mode == 2'b10) ? "R5" : "R2";
      chk(rx_synced == m_sync, {stag, " rx_synced"}, rx_synced, m_sync);
      chk(byte_valid == m_vld, "R10 byte_valid", byte_valid, m_vld);
      if (m_vld && byte_valid) begin
        chk(byte_data == m_data, "R6 byte_data", byte_data, m_data);
        chk(byte_nbits == m_nb[3:0], "R7 byte_nbits", byte_nbits, m_nb);
        chk(byte_last == m_last, "R7 byte_last", byte_last, m_last);
      end
      exp_line = (chan_en && m_rel) ? tx_src_bit : 1'b1;
      chk(tx_line == exp_line, "R8 tx_line", tx_line, exp_line);
      chk(tx_take == (chan_en && m_rel && bit_en), "R8 tx_take", tx_take,
          chan_en && m_rel && bit_en);
      if (byte_valid && byte_ready) begin
        gd.push_back(byte_data); gn.push_back(byte_nbits); gl.push_back(byte_last);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic send_bits(input logic [31:0] v, input int n, input bit en_first = 0);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      if (en_first && i == n - 1) chan_en = 1;
      bit_en = 1;
      rx_bit = v[i];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_en = 0;
    end
  endtask

  task automatic set_en(input bit v);
    @(negedge clk); chan_en = v; bit_en = 0;
  endtask

  task automatic set_link(input bit v);
    @(negedge clk); link_n = v; bit_en = 0;
  endtask

  task automatic set_ready(input bit v);
    @(negedge clk); byte_ready = v; bit_en = 0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1;
    idle(4);
    // R1: reset state
    chk(byte_valid == 0, "R1 byte_valid", byte_valid, 0);
    chk(rx_synced == 0, "R1 rx_synced", rx_synced, 0);
    chk(tx_line == 1 && tx_take == 0, "R1 tx idle", {tx_line, tx_take}, 2'b10);

    // R2/R6/R7/R8/R11: word mode with follow
    start_mode = 2'b00; sync_word = 16'hA5C3; tx_follow = 1;
    set_en(1);
    send_bits(5'b10110, 5);
    send_bits(16'hA5C3, 16);
    idle(1);
    chk(rx_synced == 1, "R2 synced after word", rx_synced, 1);
    chk(gd.size() == 0, "R2 no bytes before word", gd.size(), 0);
    send_bits(8'h3C, 8);
    send_bits(8'h81, 8);
    set_link(0);
    send_bits(3'b101, 3);
    set_link(1);
    idle(6);
    chk(gd.size() == 3, "R6 byte count", gd.size(), 3);
    if (gd.size() == 3) begin
      chk(gd[0] == 8'h3C && gn[0] == 8, "R6 first byte", gd[0], 8'h3C);
      chk(gd[1] == 8'h81 && !gl[1], "R6 second byte", gd[1], 8'h81);
      chk(gd[2] == 8'hA0 && gn[2] == 3 && gl[2], "R7 flush", {gd[2], gn[2][3:0]}, 12'hA03);
    end
    chk(rx_synced == 0, "R7 re-hunt", rx_synced, 0);

    // R3: short history must not match
    set_en(0);
    sync_word = 16'h0003;
    set_en(1);
    send_bits(2'b11, 2);
    idle(2);
    chk(rx_synced == 0, "R3 no early match", rx_synced, 0);
    send_bits(16'h0003, 16);
    idle(1);
    chk(rx_synced == 1, "R3 match after fill", rx_synced, 1);

    // R9: disable and re-hunt
    set_en(0);
    idle(1);
    chk(rx_synced == 0, "R9 cleared", rx_synced, 0);
    set_en(1);
    send_bits(16'h00F3, 16);
    idle(1);
    chk(rx_synced == 0, "R9 hunting again", rx_synced, 0);
    send_bits(16'h0003, 16);
    idle(1);
    chk(rx_synced == 1, "R9 resynced", rx_synced, 1);

    // R11: falling link edge ignored in word mode
    set_en(0);
    sync_word = 16'hA5C3;
    set_en(1);
    base = gd.size();
    set_link(0);
    idle(4);
    send_bits(8'h5A, 8);
    idle(3);
    chk(rx_synced == 0 && gd.size() == base, "R11 edge ignored", rx_synced, 0);
    set_link(1);
    idle(4);

    // R4: open mode, first bit kept, transmit released at enable
    set_en(0);
    start_mode = 2'b01; tx_follow = 0; tx_src_bit = 0;
    base = gd.size();
    send_bits(16'hF00F, 16, 1);
    idle(2);
    chk(gd.size() == base + 2, "R4 two bytes", gd.size(), base + 2);
    if (gd.size() == base + 2) begin
      chk(gd[base] == 8'hF0, "R4 first bit kept", gd[base], 8'hF0);
      chk(gd[base+1] == 8'h0F, "R6 second open byte", gd[base+1], 8'h0F);
    end
    chk(tx_line == 0, "R8 released without follow", tx_line, 0);

    // R10: back-pressure
    set_en(0);
    set_ready(0);
    set_en(1);
    base = gd.size();
    send_bits(24'hAA5533, 24);
    idle(2);
    chk(byte_valid && byte_data == 8'hAA, "R10 held byte", byte_data, 8'hAA);
    set_ready(1);
    idle(3);
    chk(gd.size() == base + 1, "R10 later bytes dropped", gd.size(), base + 1);

    // R5/R7: strobe mode and empty flush
    set_en(0);
    start_mode = 2'b10;
    set_en(1);
    base = gd.size();
    send_bits(8'hFF, 8);
    set_link(0);
    idle(3);
    chk(rx_synced == 1, "R5 synced by strobe", rx_synced, 1);
    send_bits(8'h69, 8);
    idle(2);
    chk(gd.size() == base + 1 && gd[gd.size()-1] == 8'h69, "R5 data after strobe",
        gd[gd.size()-1], 8'h69);
    set_link(1);
    idle(4);
    chk(gd.size() == base + 2 && gn[gn.size()-1] == 0 && gl[gl.size()-1],
        "R7 empty flush marker", gn[gn.size()-1], 0);
    chk(rx_synced == 0, "R7 strobe re-hunt", rx_synced, 0);

    // random stress across modes, model compared every clock
    for (int seg = 0; seg < 6; seg++) begin
      set_en(0);
      start_mode = 2'(seg % 3);
      tx_follow = seg[0];
      sync_word = 16'hB38E;
      set_en(1);
      if (seg % 3 == 0) send_bits(16'hB38E, 16);
      for (int c = 0; c < 500; c++) begin
        @(negedge clk);
        bit_en = ($urandom_range(0, 3) != 0);
        rx_bit = 1'($urandom);
        tx_src_bit = 1'($urandom);
        byte_ready = ($urandom_range(0, 4) != 0);
        if ($urandom_range(0, 29) == 0) link_n = ~link_n;
      end
    end
    idle(2);
    set_ready(1);
    set_link(1);
    idle(4);

    done = 1;
    summary();
    $finish;
  end

endmodule